// File: doc/BRIEF.md
# Round-Robin Single-Buffer DMA Engine

A four-channel memory-to-memory copy engine. Each channel holds a source pointer, a destination pointer, a byte length and a control word. Software programs these over a small word-addressed register port. Each pulse on `tick` lets the engine visit one channel. The visited channel is chosen by a pointer that rotates through the channels. A running channel with bytes left gets one burst. The burst is a chain of 32-bit reads from the source, each followed by a write of that word to the destination. A running channel with nothing left is retired and raises its completion bit.

Each channel has a fault-injection countdown for testing driver error paths. While the countdown is nonzero it drops by one on every visit. The visit that brings it to zero aborts the channel: the channel raises its error bit and moves no data. Completion and error bits are cleared by writing ones to them. A single level interrupt stays high while any of these bits is set.

Top module: `rrdma_engine`

## Requirements
- R1: The engine keeps a channel pointer that resets to 0. A `tick` taken while no burst is active visits the pointed channel. The pointer steps to the next channel, wrapping from 3 to 0, after every visit. This happens whether or not the channel was running. For a visit that starts a burst, the step happens on the cycle the burst ends.
- R2: Register map. `reg_addr` is {global, channel[1:0], field[1:0]}. With global=0 the field selects 0 source, 1 destination, 2 length and 3 control. The control word has run in bit 31 and the fault countdown in bits 7:0. With global=1, `reg_addr[0]`=0 selects the completion bits and 1 selects the error bits, both in bits 3:0. Everything reads 0 after reset. A visit to a channel whose run bit is clear changes nothing but the pointer.
- R3: A visit to a running channel with nonzero length moves min(length, 0x800) bytes. Each word is read from the source address in one cycle, and the data returned on the next cycle is written to the destination. The length drops by the bytes moved and both addresses advance by the same amount.
- R4: A visit to a running channel whose length is 0 clears its run bit and sets its completion bit.
- R5: A visit to a running channel with a nonzero countdown decrements the countdown. If the countdown reaches 0, the run bit clears, the error bit sets and no data moves. Otherwise the visit proceeds as in R3 or R4.
- R6: The length register keeps 13 bits (maximum 0x1FFF). The low two bits of both address registers always read 0.
- R7: A control write that sets run while the length's low two bits are nonzero leaves run clear and sets the channel's error bit. Length writes are ignored while run is set.
- R8: Writing 0 to run stops a channel. Later visits move no data, and its length and addresses hold.
- R9: Writing ones to the completion or error bits clears them. A bit that the engine sets in the same cycle stays set.
- R10: `irq` is high exactly while any completion or error bit is set.
- R11: `busy` is high for the two cycles of every word in a burst. Ticks during `busy` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Service tick, one visit per accepted pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_rd | output | 1 | Memory read strobe, data expected on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | Burst in progress |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall in the same cycle: the engine setting a completion bit on a visit, and software writing ones to clear the completion register. The bench provokes this by putting a tick and a clear-all write on the same cycle, four times in a row, while one channel runs with zero length. One of those four visits retires that channel. The completion register is read after each cycle and compared against a reference model. In that model the engine's set takes priority over the clear, so the retiring channel's bit must survive exactly that one cycle. A second overlap is also covered: ticks that arrive during a burst are dropped, and the bench judges this from the timing of `busy` and of the memory writes.

// File: rtl/rrdma_pkg.sv
package rrdma_pkg;
   typedef enum logic [1:0] {
      FLD_SRC = 2'd0,
      FLD_DST = 2'd1,
      FLD_LEN = 2'd2,
      FLD_CTL = 2'd3
   } fld_sel_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RD   = 2'd1,
      SEQ_WR   = 2'd2
   } seq_state_e;

   localparam int CTL_RUN_BIT = 31;
   localparam int WORD_BYTES  = 4;
endpackage

// File: rtl/rrdma_chan.sv
module rrdma_chan
   import rrdma_pkg::*;
#(
   parameter int AW     = 32,
   parameter int LEN_W  = 13,
   parameter int FAIL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  fld_sel_e          sw_sel,
   input  logic [31:0]       sw_wdata,
   input  logic              hw_stop,
   input  logic              hw_fail_dec,
   input  logic              hw_wb,
   input  logic [AW-1:0]     wb_src,
   input  logic [AW-1:0]     wb_dst,
   input  logic [LEN_W-1:0]  wb_len,
   output logic [AW-1:0]     src,
   output logic [AW-1:0]     dst,
   output logic [LEN_W-1:0]  len,
   output logic              run,
   output logic [FAIL_W-1:0] fail,
   output logic              reject
);
   // a start request with a length that is not a whole number of words
   assign reject = sw_we && (sw_sel == FLD_CTL) && sw_wdata[CTL_RUN_BIT] && (len[1:0] != 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src  <= '0;
         dst  <= '0;
         len  <= '0;
         run  <= 1'b0;
         fail <= '0;
      end else begin
         if (hw_wb) begin
            src <= wb_src;
            dst <= wb_dst;
            len <= wb_len;
         end
         if (hw_stop)     run  <= 1'b0;
         if (hw_fail_dec) fail <= fail - 1'b1;
         // software access lands last and so takes priority
         if (sw_we) begin
            unique case (sw_sel)
               FLD_SRC: src <= {sw_wdata[AW-1:2], 2'b00};
               FLD_DST: dst <= {sw_wdata[AW-1:2], 2'b00};
               FLD_LEN: if (!run) len <= sw_wdata[LEN_W-1:0];
               FLD_CTL: begin
                  run  <= sw_wdata[CTL_RUN_BIT] && !reject;
                  fail <= sw_wdata[FAIL_W-1:0];
               end
               default: ;
            endcase
         end
      end
   end

   AST_RUN_LEN_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (len[1:0] == 2'b00)); // R7

   AST_REJECT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> !run); // R7

   AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (src[1:0] == 2'b00) && (dst[1:0] == 2'b00)); // R6
endmodule

// File: rtl/rrdma_sched.sv
module rrdma_sched #(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   output logic [CH_W-1:0] ptr
);
   generate
      if (NCH == (1 << CH_W)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)       ptr <= '0;
            else if (advance) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)       ptr <= '0;
            else if (advance) ptr <= (ptr == CH_W'(NCH - 1)) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   AST_PTR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (ptr == (($past(ptr) == CH_W'(NCH - 1)) ? '0 : $past(ptr) + 1'b1))); // R1

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr)); // R1
endmodule

// File: rtl/rrdma_copy.sv
module rrdma_copy
   import rrdma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int WORDS_W   = 10,
   parameter int MAX_WORDS = 512
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [AW-1:0]      start_src,
   input  logic [AW-1:0]      start_dst,
   input  logic [WORDS_W-1:0] start_words,
   output logic               mem_rd,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic               busy,
   output logic               finish,
   output logic [AW-1:0]      end_src,
   output logic [AW-1:0]      end_dst
);
   seq_state_e         state;
   logic [AW-1:0]      cur_src;
   logic [AW-1:0]      cur_dst;
   logic [WORDS_W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         cur_src <= '0;
         cur_dst <= '0;
         left    <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (start) begin
               cur_src <= start_src;
               cur_dst <= start_dst;
               left    <= start_words;
               state   <= SEQ_RD;
            end
            SEQ_RD: state <= SEQ_WR;
            SEQ_WR: begin
               cur_src <= end_src;
               cur_dst <= end_dst;
               left    <= left - 1'b1;
               state   <= (left == WORDS_W'(1)) ? SEQ_IDLE : SEQ_RD;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state != SEQ_IDLE);
   assign mem_rd    = (state == SEQ_RD);
   assign mem_we    = (state == SEQ_WR);
   assign mem_addr  = mem_rd ? cur_src : cur_dst;
   assign mem_wdata = mem_rdata;
   assign finish    = mem_we && (left == WORDS_W'(1));
   assign end_src   = cur_src + AW'(WORD_BYTES);
   assign end_dst   = cur_dst + AW'(WORD_BYTES);

   AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_rd)); // R3

   AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((left != '0) && (left <= WORDS_W'(MAX_WORDS)))); // R3

   AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_we) |-> (mem_addr[1:0] == 2'b00)); // R6

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> mem_rd); // R11
endmodule

// File: rtl/rrdma_engine.sv
module rrdma_engine
   import rrdma_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int AW          = 32,
   parameter int LEN_W       = 13,
   parameter int FAIL_W      = 8,
   parameter int BURST_BYTES = 2048,
   localparam int CH_W       = $clog2(NCH),
   localparam int RA_W       = CH_W + 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic            mem_rd,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   input  logic [31:0]     mem_rdata,
   output logic            busy,
   output logic            irq
);
   localparam int MAX_WORDS = BURST_BYTES / WORD_BYTES;
   localparam int WORDS_W   = $clog2(MAX_WORDS + 1);

   // elaboration-time parameter checks
   if (NCH < 2 || NCH > 32)                    begin : g_bad_nch   $error("NCH out of range");          end
   if (AW != 32)                               begin : g_bad_aw    $error("AW must match data width");  end
   if (LEN_W < 3 || LEN_W > 31)                begin : g_bad_len   $error("LEN_W out of range");        end
   if (FAIL_W < 1 || FAIL_W > 24)              begin : g_bad_fail  $error("FAIL_W out of range");       end
   if (BURST_BYTES < 4 || BURST_BYTES % 4 != 0) begin : g_bad_burst $error("BURST_BYTES must be words"); end

   // register decode
   logic            glb_sel;
   logic [CH_W-1:0] reg_ch;
   fld_sel_e        reg_fld;
   assign glb_sel = reg_addr[RA_W-1];
   assign reg_ch  = reg_addr[CH_W+1:2];
   assign reg_fld = fld_sel_e'(reg_addr[1:0]);

   logic done_wr, err_wr;
   assign done_wr = reg_we && glb_sel && !reg_addr[0];
   assign err_wr  = reg_we && glb_sel &&  reg_addr[0];

   // channel state
   logic [AW-1:0]     ch_src  [NCH];
   logic [AW-1:0]     ch_dst  [NCH];
   logic [LEN_W-1:0]  ch_len  [NCH];
   logic [FAIL_W-1:0] ch_fail [NCH];
   logic [NCH-1:0]    ch_run, ch_reject, ch_stop, ch_fdec, ch_wb;

   logic [CH_W-1:0]  ptr;
   logic             copy_busy, copy_finish;
   logic [AW-1:0]    end_src, end_dst;
   logic [LEN_W-1:0] burst_len_q;
   logic [LEN_W-1:0] wb_len;

   // visit decisions for the pointed channel
   logic             visit, v_active, do_fail, do_done, do_burst;
   logic [LEN_W-1:0] v_len, take;
   assign visit    = tick && !copy_busy;
   assign v_len    = ch_len[ptr];
   assign v_active = visit && ch_run[ptr];
   assign do_fail  = v_active && (ch_fail[ptr] == FAIL_W'(1));
   assign do_done  = v_active && !do_fail && (v_len == '0);
   assign do_burst = v_active && !do_fail && (v_len != '0);
   assign take     = (int'(v_len) > BURST_BYTES) ? LEN_W'(BURST_BYTES) : v_len;
   assign wb_len   = ch_len[ptr] - burst_len_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        burst_len_q <= '0;
      else if (do_burst) burst_len_q <= take;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic hit;
      assign hit          = (ptr == CH_W'(g));
      assign ch_stop[g]   = hit && (do_fail || do_done);
      assign ch_fdec[g]   = hit && v_active && (ch_fail[g] != '0);
      assign ch_wb[g]     = hit && copy_finish;

      rrdma_chan #(.AW(AW), .LEN_W(LEN_W), .FAIL_W(FAIL_W)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .sw_we       (reg_we && !glb_sel && (reg_ch == CH_W'(g))),
         .sw_sel      (reg_fld),
         .sw_wdata    (reg_wdata),
         .hw_stop     (ch_stop[g]),
         .hw_fail_dec (ch_fdec[g]),
         .hw_wb       (ch_wb[g]),
         .wb_src      (end_src),
         .wb_dst      (end_dst),
         .wb_len      (wb_len),
         .src         (ch_src[g]),
         .dst         (ch_dst[g]),
         .len         (ch_len[g]),
         .run         (ch_run[g]),
         .fail        (ch_fail[g]),
         .reject      (ch_reject[g])
      );
   end

   rrdma_sched #(.NCH(NCH), .CH_W(CH_W)) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance ((visit && !do_burst) || copy_finish),
      .ptr     (ptr)
   );

   rrdma_copy #(.AW(AW), .WORDS_W(WORDS_W), .MAX_WORDS(MAX_WORDS)) u_copy (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (do_burst),
      .start_src   (ch_src[ptr]),
      .start_dst   (ch_dst[ptr]),
      .start_words (WORDS_W'(take >> 2)),
      .mem_rd      (mem_rd),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .busy        (copy_busy),
      .finish      (copy_finish),
      .end_src     (end_src),
      .end_dst     (end_dst)
   );

   // interrupt bits: engine sets beat software clears
   logic [NCH-1:0] done_q, err_q, ptr_hot;
   assign ptr_hot = NCH'(1) << ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= '0;
         err_q  <= '0;
      end else begin
         done_q <= (done_q & ~(done_wr ? reg_wdata[NCH-1:0] : '0)) | (do_done ? ptr_hot : '0);
         err_q  <= (err_q  & ~(err_wr  ? reg_wdata[NCH-1:0] : '0)) | (do_fail ? ptr_hot : '0) | ch_reject;
      end
   end

   assign irq  = (done_q != '0) || (err_q != '0);
   assign busy = copy_busy;

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (glb_sel) begin
         reg_rdata[NCH-1:0] = reg_addr[0] ? err_q : done_q;
      end else begin
         unique case (reg_fld)
            FLD_SRC: reg_rdata = ch_src[reg_ch];
            FLD_DST: reg_rdata = ch_dst[reg_ch];
            FLD_LEN: reg_rdata = 32'(ch_len[reg_ch]);
            FLD_CTL: begin
               reg_rdata[CTL_RUN_BIT] = ch_run[reg_ch];
               reg_rdata[FAIL_W-1:0]  = ch_fail[reg_ch];
            end
            default: ;
         endcase
      end
   end

   AST_DONE_ONLY_ON_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_q & ~$past(done_q)) != '0) |-> $past(visit)); // R4

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_q & ~$past(err_q)) != '0) |-> ($past(do_fail) || ($past(ch_reject) != '0))); // R5

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (do_done && done_wr) |=> done_q[$past(ptr)]); // R9

   AST_PTR_FROZEN_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_busy && !copy_finish) |=> $stable(ptr)); // R11

   AST_SKIP_IDLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      (visit && !ch_run[ptr]) |=> !copy_busy); // R2
endmodule

// File: tb/sim_rrdma_engine.sv
module sim_rrdma_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int BURST = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_rd, mem_we, busy, irq;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rrdma_engine u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // backing memory
   logic [31:0] mem [logic [31:0]];
   function automatic logic [31:0] memval(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return a ^ 32'h5A3C_0F96;
   endfunction

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= memval(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
   end

   // reference model
   int unsigned m_src [NCH];
   int unsigned m_dst [NCH];
   int          m_len [NCH];
   int          m_fail[NCH];
   bit          m_run [NCH];
   bit [3:0]    m_done, m_err;
   int          m_ptr, m_left;
   logic [63:0] exp_q[$];

   always @(posedge clk) begin
      int  o_run[NCH];
      int  o_len[NCH];
      int  c, n;
      bit  failnow;
      bit [3:0] sd, se, cd, ce;
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_len[i] = 0; m_fail[i] = 0; m_run[i] = 0;
         end
         m_done = 0; m_err = 0; m_ptr = 0; m_left = 0;
         exp_q.delete();
      end else begin
         for (int i = 0; i < NCH; i++) begin o_run[i] = m_run[i]; o_len[i] = m_len[i]; end
         sd = 0; se = 0; cd = 0; ce = 0;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_ptr = (m_ptr + 1) % NCH;
         end else if (tick) begin
            c = m_ptr;
            if (m_run[c]) begin
               failnow = 0;
               if (m_fail[c] > 0) begin
                  m_fail[c]--;
                  if (m_fail[c] == 0) failnow = 1;
               end
               if (failnow) begin
                  m_run[c] = 0; se[c] = 1;
               end else if (m_len[c] == 0) begin
                  m_run[c] = 0; sd[c] = 1;
               end else begin
                  n = (m_len[c] > BURST) ? BURST : m_len[c];
                  for (int w = 0; w < n / 4; w++)
                     exp_q.push_back({m_dst[c] + 32'(4 * w), memval(m_src[c] + 32'(4 * w))});
                  m_src[c] += n; m_dst[c] += n; m_len[c] -= n;
                  m_left = 2 * (n / 4);
               end
            end
            if (m_left == 0) m_ptr = (m_ptr + 1) % NCH;
         end
         if (reg_we) begin
            if (reg_addr[4]) begin
               if (reg_addr[0]) ce = reg_wdata[3:0];
               else             cd = reg_wdata[3:0];
            end else begin
               c = int'(reg_addr[3:2]);
               case (reg_addr[1:0])
                  2'd0: m_src[c] = reg_wdata & ~32'd3;
                  2'd1: m_dst[c] = reg_wdata & ~32'd3;
                  2'd2: if (o_run[c] == 0) m_len[c] = int'(reg_wdata & 32'h1FFF);
                  default: begin
                     m_fail[c] = int'(reg_wdata[7:0]);
                     if (reg_wdata[31] && (o_len[c] % 4) != 0) begin
                        m_run[c] = 0; se[c] = 1;
                     end else m_run[c] = reg_wdata[31];
                  end
               endcase
            end
         end
         m_done = (m_done & ~cd) | sd;
         m_err  = (m_err & ~ce) | se;
      end
   end

   function automatic logic [31:0] mreg(input logic [4:0] a);
      int c;
      c = int'(a[3:2]);
      if (a[4]) return a[0] ? {28'd0, m_err} : {28'd0, m_done};
      case (a[1:0])
         2'd0: return m_src[c];
         2'd1: return m_dst[c];
         2'd2: return 32'(m_len[c]);
         default: return {m_run[c], 23'd0, 8'(m_fail[c])};
      endcase
   endfunction

   // per-clock comparison
   always @(negedge clk) begin
      logic [63:0] e;
      if (rst_n && !finished) begin
         check(busy == (m_left > 0), "R11 busy", 32'(busy), 32'(m_left > 0));
         check(irq == ((m_done | m_err) != 0), "R10 irq", 32'(irq), 32'((m_done | m_err) != 0));
         if (mem_we) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
            else begin
               e = exp_q.pop_front();
               check(mem_addr == e[63:32], "R3 write address", mem_addr, e[63:32]);
               check(mem_wdata == e[31:0], "R3 write data", mem_wdata, e[31:0]);
            end
         end
      end
   end

   function automatic logic [4:0] ra(input int ch, input int fld);
      return {1'b0, 2'(ch), 2'(fld)};
   endfunction
   localparam logic [4:0] A_DONE = 5'b10000;
   localparam logic [4:0] A_ERR  = 5'b10001;

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == mreg(a), tag, reg_rdata, mreg(a));
   endtask

   task automatic tick_wait();
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      while (busy) @(negedge clk);
   endtask

   task automatic run_out(input int c);
      for (int k = 0; k < 40 && m_run[c]; k++) tick_wait();
   endtask

   task automatic chk_chan(input int c, input string tag);
      for (int f = 0; f < 4; f++) rd_chk(ra(c, f), tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2: reset state
      for (int c = 0; c < NCH; c++) chk_chan(c, "R2 reset");
      rd_chk(A_DONE, "R2 reset done"); rd_chk(A_ERR, "R2 reset err");
      // R1/R2: idle rotation with no running channel
      repeat (3) tick_wait();
      // R3/R4: two-burst transfer on channel 1
      wr(ra(1, 0), 32'h0000_1000); wr(ra(1, 1), 32'h0000_4000);
      wr(ra(1, 2), 32'h0000_1000); wr(ra(1, 3), 32'h8000_0000);
      run_out(1);
      chk_chan(1, "R3 after transfer");
      rd_chk(A_DONE, "R4 completion bit");
      wr(A_DONE, 32'hF);
      rd_chk(A_DONE, "R9 cleared");
      // R3: length under one burst, odd words
      wr(ra(2, 0), 32'h0000_8000); wr(ra(2, 1), 32'h0000_9000);
      wr(ra(2, 2), 32'h0000_000C); wr(ra(2, 3), 32'h8000_0000);
      run_out(2);
      chk_chan(2, "R3 short transfer");
      // R6: address low bits and length width
      wr(ra(0, 0), 32'h0000_2003); wr(ra(0, 1), 32'h0000_3002);
      wr(ra(3, 2), 32'hFFFF_FFFF);
      rd_chk(ra(0, 0), "R6 src low bits"); rd_chk(ra(0, 1), "R6 dst low bits");
      rd_chk(ra(3, 2), "R6 length width");
      // R7: misaligned start rejected
      wr(ra(3, 3), 32'h8000_0000);
      rd_chk(ra(3, 3), "R7 run stays clear"); rd_chk(A_ERR, "R7 error bit");
      wr(A_ERR, 32'hF);
      // R7: length locked while running, R8: stop holds state
      wr(ra(0, 2), 32'h0000_1000); wr(ra(0, 3), 32'h8000_0000);
      wr(ra(0, 2), 32'h0000_0010);
      rd_chk(ra(0, 2), "R7 length locked");
      for (int k = 0; k < 8 && m_len[0] == 32'h1000; k++) tick_wait();
      wr(ra(0, 3), 32'h0000_0000);
      repeat (6) tick_wait();
      chk_chan(0, "R8 stopped channel holds");
      // R5: countdown of 2 gives one burst then an error
      wr(ra(2, 0), 32'h0001_0000); wr(ra(2, 1), 32'h0002_0000);
      wr(ra(2, 2), 32'h0000_1000); wr(ra(2, 3), 32'h8000_0002);
      run_out(2);
      chk_chan(2, "R5 aborted channel");
      rd_chk(A_ERR, "R5 error bit"); rd_chk(A_DONE, "R5 no completion");
      wr(A_ERR, 32'hF);
      // R11: ticks during a full burst are dropped
      wr(ra(3, 0), 32'h0003_0000); wr(ra(3, 1), 32'h0004_0000);
      wr(ra(3, 2), 32'h0000_0800); wr(ra(3, 3), 32'h8000_0000);
      for (int k = 0; k < 8 && !busy; k++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
      repeat (5) begin
         repeat (50) @(negedge clk);
         tick = 1; @(negedge clk); tick = 0;
      end
      while (busy) @(negedge clk);
      run_out(3);
      chk_chan(3, "R11 burst unaffected");
      wr(A_DONE, 32'hF);
      // R9: clear-all write in the same cycle as a completion
      wr(ra(1, 3), 32'h8000_0000);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         tick = 1; reg_we = 1; reg_addr = A_DONE; reg_wdata = 32'hF;
         @(negedge clk);
         tick = 0; reg_we = 0;
         rd_chk(A_DONE, "R9 set beats clear");
      end
      wr(A_DONE, 32'hF);
      rd_chk(A_DONE, "R10 all clear");
      rd_chk(A_ERR, "R10 all clear err");
      repeat (4) @(negedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule